// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is a single timer channel built around a down-counter. Software stages a reload count and a threshold value in two holding registers. The running counter and the active threshold do not see those writes directly. The values move across only when a preload control bit is set, or when the counter wraps at zero with automatic reload enabled. The counter steps down by one on every cycle in which the clock-tree tick enable is high and the channel is running. The output pin goes high once the count falls to or below the active threshold.

A control register holds three bits: run, preload and auto-reload. To arm the channel, software writes run=0, preload=1, auto-reload=1. This leaves both active registers loaded and the counter halted. A following write of run=1 with preload=0 starts counting. A one-cycle pulse marks each arrival at zero. The live count is visible for readback. Setting the `HAS_PWM` parameter to 0 ties the pin low, so the same module can serve as a tick-only interval channel.

Top module: `dbuf_pwm_channel`

## Requirements
- R1: After reset, `count_value` is 0 and both `pwm_out` and `zero_pulse` are low. `pwm_out` stays low until the first preload after reset.
- R2: A write to either holding register leaves the running count and the active threshold unchanged. The counter keeps stepping down from its current value.
- R3: A control write takes effect at the clock edge after it is sampled. While the preload bit is held set, each clock edge copies both holding registers into the active count and the active threshold, and no counting occurs, even if run is also set.
- R4: With run set and preload clear, the count drops by exactly one on each clock edge where `tick_en` is high. It holds when `tick_en` is low or when run is clear.
- R5: With auto-reload set, a tick taken at count 0 reloads the count from the count holding register and the threshold from the threshold holding register. For a holding value N, this gives a period of N+1 ticks, and a newly written threshold takes effect only from that reload onward.
- R6: With auto-reload clear, the count stays at 0 once it gets there.
- R7: After a preload, `pwm_out` is high exactly when the count is less than or equal to the active threshold, and is updated in the same cycle as the count.
- R8: `zero_pulse` is high for one cycle, in the cycle where the count first reads 0 after stepping down from 1.
- R9: When `HAS_PWM` is 0, `pwm_out` is always low, and counting and `zero_pulse` behave as in the PWM variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-step enable from the clock tree |
| cnt_buf_we | input | 1 | Write strobe for the count holding register |
| cnt_buf_data | input | WIDTH | Value for the count holding register |
| cmp_buf_we | input | 1 | Write strobe for the threshold holding register |
| cmp_buf_data | input | WIDTH | Value for the threshold holding register |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_run | input | 1 | Run bit |
| ctl_load | input | 1 | Preload bit |
| ctl_reload | input | 1 | Auto-reload bit |
| pwm_out | output | 1 | Pin level |
| zero_pulse | output | 1 | One-cycle pulse when the count reaches zero |
| count_value | output | WIDTH | Live count |

## Verification
The assertions watch the following on every cycle:
- the single-step decrement;
- the hold when no tick arrives;
- the copy made during preload;
- the hold at zero in one-shot mode;
- the link between the zero pulse and a zero count;
- the pin level against the active count and threshold.

The bench scenarios cover what those local rules cannot show:
- the full reload period for each small count and threshold pair;
- the threshold swap that waits for the next reload;
- the one-cycle delay of control writes;
- the fact that holding-register writes leave the running count alone.

The bench also runs a tick-only instance alongside the main one to show its pin never rises while its count follows the PWM variant.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;

   // control bits as held in the channel
   typedef struct packed {
      logic run;
      logic preload;
      logic autoreload;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{run: 1'b0, preload: 1'b0, autoreload: 1'b0};

endpackage

// File: rtl/dbuf_pwm_shadow.sv
// One software-written holding register; the active copy lives elsewhere.
module dbuf_pwm_shadow #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] value
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (we) begin
         value <= wdata;
      end
   end

endmodule

// File: rtl/dbuf_pwm_ctrl.sv
// Control register: run, preload and auto-reload, captured on a write strobe.
module dbuf_pwm_ctrl
   import dbuf_pwm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic run,
   input  logic preload,
   input  logic autoreload,
   output ctl_t ctl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= CTL_RESET;
      end else if (we) begin
         ctl.run        <= run;
         ctl.preload    <= preload;
         ctl.autoreload <= autoreload;
      end
   end

   // R3: a control write lands one edge later
   AST_CTL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ctl.run == $past(run)) && (ctl.preload == $past(preload))
             && (ctl.autoreload == $past(autoreload))); // R3

endmodule

// File: rtl/dbuf_pwm_counter.sv
// Active count and active threshold, with the preload / wrap transfer rules.
module dbuf_pwm_counter
   import dbuf_pwm_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  ctl_t             ctl,
   input  logic [WIDTH-1:0] cnt_buf,
   input  logic [WIDTH-1:0] cmp_buf,
   output logic [WIDTH-1:0] cnt_q,
   output logic [WIDTH-1:0] cmp_q,
   output logic [WIDTH-1:0] cnt_d,
   output logic [WIDTH-1:0] cmp_d,
   output logic             loaded_q,
   output logic             loaded_d,
   output logic             zero_pulse
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic step_ok;
   logic hit_d;

   assign step_ok = ctl.run && !ctl.preload && tick_en;

   always_comb begin
      cnt_d    = cnt_q;
      cmp_d    = cmp_q;
      loaded_d = loaded_q;
      hit_d    = 1'b0;
      if (ctl.preload) begin
         cnt_d    = cnt_buf;
         cmp_d    = cmp_buf;
         loaded_d = 1'b1;
      end else if (step_ok) begin
         if (cnt_q == '0) begin
            if (ctl.autoreload) begin
               cnt_d = cnt_buf;
               cmp_d = cmp_buf;
            end
         end else begin
            cnt_d = cnt_q - ONE;
            hit_d = (cnt_q == ONE);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         cmp_q      <= '0;
         loaded_q   <= 1'b0;
         zero_pulse <= 1'b0;
      end else begin
         cnt_q      <= cnt_d;
         cmp_q      <= cmp_d;
         loaded_q   <= loaded_d;
         zero_pulse <= hit_d;
      end
   end

   AST_PRELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.preload |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf))); // R3

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.preload && !(ctl.run && tick_en)) |=> $stable(cnt_q) && $stable(cmp_q)); // R4

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ok && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE); // R4

   AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ok && cnt_q == '0 && ctl.autoreload) |=> cnt_q == $past(cnt_buf)); // R5

   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ok && cnt_q == '0 && !ctl.autoreload) |=> cnt_q == '0); // R6

   AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      zero_pulse |-> (cnt_q == '0) && ($past(cnt_q) == ONE)); // R8

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      zero_pulse |=> !zero_pulse); // R8

endmodule

// File: rtl/dbuf_pwm_outgen.sv
// Pin level generator; a parameter selects a real PWM stage or a tied-low pin.
module dbuf_pwm_outgen #(
   parameter int WIDTH   = 16,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loaded_d,
   input  logic [WIDTH-1:0] cnt_d,
   input  logic [WIDTH-1:0] cmp_d,
   output logic             pwm
);

   generate
      if (HAS_PWM) begin : g_pwm
         logic level_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level_q <= 1'b0;
            end else begin
               level_q <= loaded_d && (cnt_d <= cmp_d);
            end
         end
         assign pwm = level_q;
      end else begin : g_tick_only
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, loaded_d, cnt_d, cmp_d};
         assign pwm = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dbuf_pwm_channel.sv
module dbuf_pwm_channel
   import dbuf_pwm_pkg::*;
#(
   parameter int WIDTH   = 16,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cnt_buf_we,
   input  logic [WIDTH-1:0] cnt_buf_data,
   input  logic             cmp_buf_we,
   input  logic [WIDTH-1:0] cmp_buf_data,
   input  logic             ctl_we,
   input  logic             ctl_run,
   input  logic             ctl_load,
   input  logic             ctl_reload,
   output logic             pwm_out,
   output logic             zero_pulse,
   output logic [WIDTH-1:0] count_value
);

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("dbuf_pwm_channel: WIDTH must lie in 2..32");
      end
   endgenerate

   ctl_t             ctl;
   logic [WIDTH-1:0] cnt_buf, cmp_buf;
   logic [WIDTH-1:0] cnt_q, cmp_q, cnt_d, cmp_d;
   logic             loaded_q, loaded_d;

   dbuf_pwm_shadow #(.WIDTH(WIDTH)) u_cnt_buf (
      .clk(clk), .rst_n(rst_n), .we(cnt_buf_we), .wdata(cnt_buf_data), .value(cnt_buf)
   );

   dbuf_pwm_shadow #(.WIDTH(WIDTH)) u_cmp_buf (
      .clk(clk), .rst_n(rst_n), .we(cmp_buf_we), .wdata(cmp_buf_data), .value(cmp_buf)
   );

   dbuf_pwm_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .run(ctl_run),
      .preload(ctl_load), .autoreload(ctl_reload), .ctl(ctl)
   );

   dbuf_pwm_counter #(.WIDTH(WIDTH)) u_counter (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl(ctl),
      .cnt_buf(cnt_buf), .cmp_buf(cmp_buf),
      .cnt_q(cnt_q), .cmp_q(cmp_q), .cnt_d(cnt_d), .cmp_d(cmp_d),
      .loaded_q(loaded_q), .loaded_d(loaded_d), .zero_pulse(zero_pulse)
   );

   dbuf_pwm_outgen #(.WIDTH(WIDTH), .HAS_PWM(HAS_PWM)) u_outgen (
      .clk(clk), .rst_n(rst_n), .loaded_d(loaded_d),
      .cnt_d(cnt_d), .cmp_d(cmp_d), .pwm(pwm_out)
   );

   assign count_value = cnt_q;

   generate
      if (HAS_PWM) begin : g_pwm_chk
         AST_PWM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_out == (loaded_q && (cnt_q <= cmp_q))); // R7
         AST_PWM_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            !loaded_q |-> !pwm_out); // R1
      end else begin : g_tick_chk
         AST_TICK_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            loaded_q |-> !pwm_out); // R9
      end
   endgenerate

endmodule

// File: tb/dbuf_pwm_channel_tb.sv
`timescale 1ns/1ps
module dbuf_pwm_channel_tb;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b1;
   logic         cnt_buf_we = 1'b0, cmp_buf_we = 1'b0, ctl_we = 1'b0;
   logic [W-1:0] cnt_buf_data = '0, cmp_buf_data = '0;
   logic         ctl_run = 1'b0, ctl_load = 1'b0, ctl_reload = 1'b0;
   logic         pwm_out, zero_pulse, t_pwm, t_zero;
   logic [W-1:0] count_value, t_count;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dbuf_pwm_channel #(.WIDTH(W), .HAS_PWM(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cnt_buf_we(cnt_buf_we), .cnt_buf_data(cnt_buf_data),
      .cmp_buf_we(cmp_buf_we), .cmp_buf_data(cmp_buf_data),
      .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_load(ctl_load), .ctl_reload(ctl_reload),
      .pwm_out(pwm_out), .zero_pulse(zero_pulse), .count_value(count_value)
   );

   dbuf_pwm_channel #(.WIDTH(W), .HAS_PWM(1'b0)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cnt_buf_we(cnt_buf_we), .cnt_buf_data(cnt_buf_data),
      .cmp_buf_we(cmp_buf_we), .cmp_buf_data(cmp_buf_data),
      .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_load(ctl_load), .ctl_reload(ctl_reload),
      .pwm_out(t_pwm), .zero_pulse(t_zero), .count_value(t_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_bufs(input int n, input int c);
      cnt_buf_we = 1'b1; cnt_buf_data = W'(n);
      cmp_buf_we = 1'b1; cmp_buf_data = W'(c);
      step();
      cnt_buf_we = 1'b0; cmp_buf_we = 1'b0;
   endtask

   task automatic wr_ctl(input bit run, input bit load, input bit reload);
      ctl_we = 1'b1; ctl_run = run; ctl_load = load; ctl_reload = reload;
      step();
      ctl_we = 1'b0;
   endtask

   // stage buffers, arm with preload, wait for the copy edge
   task automatic arm(input int n, input int c);
      wr_bufs(n, c);
      wr_ctl(1'b0, 1'b1, 1'b1);
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state, and pin stays low before any preload
      step();
      chk("R1 count at reset", int'(count_value), 0);
      chk("R1 pwm at reset", int'(pwm_out), 0);
      chk("R1 pulse at reset", int'(zero_pulse), 0);
      rst_n = 1'b1;
      step(); step(); step();
      chk("R1 pwm before preload", int'(pwm_out), 0);
      chk("R1 count before preload", int'(count_value), 0);

      // R5 R7 R8 R9: sweep of count and threshold with auto-reload
      for (int n = 0; n <= 5; n++) begin
         for (int c = 0; c <= 6; c++) begin
            arm(n, c);
            chk("R3 preload count", int'(count_value), n);
            chk("R7 preload pwm", int'(pwm_out), (n <= c) ? 1 : 0);
            wr_ctl(1'b1, 1'b0, 1'b1);
            for (int j = 0; j <= 2 * (n + 1); j++) begin
               int v;
               v = n - (j % (n + 1));
               chk("R5 count in period", int'(count_value), v);
               chk("R7 pwm level", int'(pwm_out), (v <= c) ? 1 : 0);
               chk("R8 zero pulse", int'(zero_pulse), (v == 0 && n > 0 && j > 0) ? 1 : 0);
               chk("R9 tick-only pin", int'(t_pwm), 0);
               chk("R9 tick-only count", int'(t_count), v);
               step();
            end
         end
      end

      // R4: tick gating and run clear
      arm(5, 2);
      wr_ctl(1'b1, 1'b0, 1'b1);
      chk("R4 start value", int'(count_value), 5);
      tick_en = 1'b0;
      step(); step(); step();
      chk("R4 hold without tick", int'(count_value), 5);
      tick_en = 1'b1;
      step();
      chk("R4 one step per tick", int'(count_value), 4);
      wr_ctl(1'b0, 1'b0, 1'b1);
      chk("R3 control lands one edge later", int'(count_value), 3);
      step(); step();
      chk("R4 hold with run clear", int'(count_value), 3);

      // R3: preload held together with run keeps copying, no counting
      arm(5, 1);
      wr_ctl(1'b1, 1'b1, 1'b1);
      step(); step(); step();
      chk("R3 held preload no count", int'(count_value), 5);
      wr_bufs(7, 1);
      step();
      chk("R3 held preload recopies", int'(count_value), 7);

      // R6: one-shot stops at zero with a single pulse
      begin
         int pulses;
         pulses = 0;
         arm(3, 1);
         wr_ctl(1'b1, 1'b0, 1'b0);
         for (int j = 0; j <= 8; j++) begin
            chk("R6 one-shot count", int'(count_value), (j < 3) ? 3 - j : 0);
            pulses += int'(zero_pulse);
            step();
         end
         chk("R8 one pulse in one-shot", pulses, 1);
      end

      // R2 R5: buffer writes mid-run touch nothing until the wrap
      arm(4, 1);
      wr_ctl(1'b1, 1'b0, 1'b1);
      chk("R2 start value", int'(count_value), 4);
      wr_bufs(9, 3);
      chk("R2 count unaffected by buffer write", int'(count_value), 3);
      chk("R5 old threshold still active", int'(pwm_out), 0);
      step(); step(); step();
      chk("R2 reached zero", int'(count_value), 0);
      step();
      chk("R5 reload from new buffer", int'(count_value), 9);
      chk("R7 pwm after reload", int'(pwm_out), 0);
      repeat (6) step();
      chk("R5 new threshold after reload count", int'(count_value), 3);
      chk("R5 new threshold after reload pwm", int'(pwm_out), 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule